// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a clocked memory model with a registered address and control front end. An access starts with one of two address strobes. The host-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls in the same cycle. When neither strobe is active, an advance input either steps a two-bit linear burst counter through the low address bits or holds the current address. In both cases the current read or write continues.

Three chip enables decide whether a started access selects the device. Writes are masked per byte over four 8-bit lanes of a shared bidirectional data bus. Read data flows through: the word at the address registered at a clock edge appears on the bus during the cycle that follows. The output enable gates the bus combinationally and has no effect during write cycles. While the sleep input is high, no access takes place and the address is held.

Top module: `burst_sram`

## Requirements
- R1: When `adspN` is low and `ce1N` is low, a read starts at `addr`, whatever the levels of `gwN`, `bweN` and `bwN`; no word is written on that edge.
- R2: A write happens on an edge where `adscN` is low (and no host-strobe start occurs) with the device selected, at `addr`. It also happens on an edge with neither strobe active, following any selected cycle, at the current or the advanced address. The data is taken from `dq` on that edge.
- R3: A write is requested when `gwN` is low (all four lanes), or when `bweN` is low and at least one bit of `bwN` is low. With `gwN` high and either `bweN` high or `bwN` all ones, the cycle is a read.
- R4: Bit `bwN[i]` low enables lane i, which is `dq[8i+7:8i]`. Lanes whose bit is high keep their stored byte.
- R5: A started access with `ce1N` high, `ce2` low or `ce3N` high deselects the device. `dq` then stays released until a later selected start, including through cycles with neither strobe active.
- R6: With neither strobe active, `advN` low on a selected access increments the low two address bits (11 wraps to 00) and leaves the upper bits unchanged.
- R7: With neither strobe active and `advN` high, the address is held.
- R8: `oeN` acts without a clock: during a selected read cycle, `dq` is driven while `oeN` is low and released while it is high.
- R9: During a write cycle, `dq` is released even while `oeN` is low.
- R10: While `zz` is high at an edge, no write occurs, strobes are ignored, the address is held and `dq` is released. Afterwards a cycle with neither strobe active resumes at the held address.
- R11: With `ce1N` high, a low `adspN` is ignored: the cycle behaves as if no strobe were active, unless `adscN` is low, which then deselects.
- R12: While `rstN` is low, and after reset, the device is deselected and `dq` is released.
- R13: Read data of the address registered at an edge is on `dq` in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| adspN | input | 1 | Host-side address strobe, active low, always a read |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| gwN | input | 1 | Global write of all lanes, active low |
| bweN | input | 1 | Byte write enable, active low |
| bwN | input | 4 | Per-lane write enables, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| dq | inout | 32 | Bidirectional data bus |

## Verification
The functions that meet in one cycle are burst advance and byte-masked writing. A neither-strobe cycle with `advN` low and a write request both steps the counter and writes at the stepped address. The bench provokes this by starting with the host strobe, writing on the held address and then writing on the advanced one. It then reads both words back to judge that each landed at its own address. The host strobe meeting active write controls is provoked the same way, and is judged by reading the unchanged word back in the following cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             wrEn;      // write on this edge
    logic [LANES-1:0] laneMask;  // lanes written
    logic             rdOut;     // current cycle is a selected read
  } bsram_strb_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              zz,
  output bsram_strb_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    baseReg, baseNxt;
  logic [BURST_W-1:0] cntReg, cntNxt;
  logic selReg, selNxt, wrReg, wrNxt, sleepReg, sleepNxt;

  logic chipSel, pStart, cStart, wrReq;
  logic [LANES-1:0] laneReq;

  // cycle decode
  always_comb begin
    chipSel = !ce1N && ce2 && !ce3N;
    pStart  = !adspN && !ce1N;
    cStart  = !adscN && !pStart;
    wrReq   = !gwN || (!bweN && !(&bwN));
    laneReq = !gwN ? '1 : (!bweN ? ~bwN : '0);
  end

  // next-state: address register, burst counter, cycle kind
  always_comb begin
    baseNxt  = baseReg;
    cntNxt   = cntReg;
    selNxt   = selReg;
    wrNxt    = wrReg;
    sleepNxt = 1'b0;
    if (zz) begin
      sleepNxt = 1'b1;
    end else if (pStart || cStart) begin
      if (chipSel) begin
        baseNxt = addr[ADDR_W-1:BURST_W];
        cntNxt  = addr[BURST_W-1:0];
        selNxt  = 1'b1;
        wrNxt   = cStart && wrReq;
      end else begin
        selNxt = 1'b0;
        wrNxt  = 1'b0;
      end
    end else if (selReg) begin
      if (!advN) cntNxt = cntReg + BURST_W'(1);
      wrNxt = wrReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      cntReg   <= '0;
      selReg   <= 1'b0;
      wrReg    <= 1'b0;
      sleepReg <= 1'b0;
    end else begin
      baseReg  <= baseNxt;
      cntReg   <= cntNxt;
      selReg   <= selNxt;
      wrReg    <= wrNxt;
      sleepReg <= sleepNxt;
    end
  end

  always_comb begin
    strb.wrEn     = !zz && selNxt && wrNxt;
    strb.laneMask = laneReq;
    strb.rdOut    = selReg && !wrReg && !sleepReg;
    wrAddr        = {baseNxt, cntNxt};
    rdAddr        = {baseReg, cntReg};
  end

  AST_PSTART_READS: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && !adspN && !ce1N) |=> (strb.rdOut == $past(ce2 && !ce3N))); // R1
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && adspN && adscN && !advN && selReg) |=>
      ((rdAddr[BURST_W-1:0] == $past(rdAddr[BURST_W-1:0]) + BURST_W'(1))
       && $stable(rdAddr[ADDR_W-1:BURST_W]))); // R6
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && adspN && adscN && advN) |=> $stable(rdAddr)); // R7
  AST_WR_MASKS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && adspN && !adscN && !gwN) |=> !strb.rdOut); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    zz |=> ($stable(rdAddr) && !strb.rdOut)); // R10
  AST_CE1_DESEL: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && ce1N && !adscN) |=> !strb.rdOut); // R11
  AST_CE1_IGNORE_P: assert property (@(posedge clk) disable iff (!rstN)
    (!zz && ce1N && adscN && advN) |=> $stable(rdAddr)); // R11
endmodule

// File: rtl/bsram_data.sv
module bsram_data
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  bsram_strb_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              oeN,
  inout  wire  [DATA_W-1:0] dq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rdWord;
  logic              driveEn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.laneMask[g])
        laneMem[wrAddr] <= dq[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end

  assign driveEn = strb.rdOut && !oeN;
  assign dq = driveEn ? rdWord : 'z;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              zz,
  inout  wire  [DATA_W-1:0] dq
);
  bsram_strb_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .zz(zz), .strb(strb), .wrAddr(wrAddr),
    .rdAddr(rdAddr)
  );

  bsram_data #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .oeN(oeN), .dq(dq)
  );
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  import bsram_pkg::*;
  localparam int AW = 6;
  localparam logic [DATA_W-1:0] REL = '1;   // released bus reads as pulled-up ones

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adspN = 1, adscN = 1, advN = 1, ce1N = 0, ce2 = 1, ce3N = 0;
  logic gwN = 1, bweN = 1, oeN = 0, zz = 0;
  logic [LANES-1:0] bwN = '1;
  logic tbDrv = 1'b0;
  logic [DATA_W-1:0] tbData = '0;
  wire  [DATA_W-1:0] dq;
  int total = 0, fails = 0;
  bit done = 0;

  assign dq = tbDrv ? tbData : 'z;
  for (genvar i = 0; i < DATA_W; i++) begin : g_pu
    pullup (dq[i]);
  end

  always #10 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .adspN(adspN), .adscN(adscN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .zz(zz), .dq(dq)
  );

  typedef struct packed {
    logic [2:0]        strb;  // {adspN, adscN, advN}
    logic [2:0]        ce;    // {ce1N, ce2, ce3N}
    logic [5:0]        wr;    // {gwN, bweN, bwN}
    logic [1:0]        oz;    // {oeN, zz}
    logic [AW-1:0]     a;
    logic              drv;
    logic [DATA_W-1:0] wd;
    logic              chk;
    logic [DATA_W-1:0] ex;
    logic [7:0]        req;
  } vec_t;

  function automatic vec_t mk(logic [2:0] s, logic [2:0] c, logic [5:0] w,
      logic [1:0] o, logic [AW-1:0] a, logic d, logic [DATA_W-1:0] wd,
      logic k, logic [DATA_W-1:0] e, logic [7:0] r);
    return {s, c, w, o, a, d, wd, k, e, r};
  endfunction

  localparam logic [2:0] SP = 3'b011, SC = 3'b101, SA = 3'b110, SH = 3'b111;
  localparam logic [2:0] CS = 3'b010;
  localparam logic [5:0] WG = 6'b011111, RD = 6'b111111;
  localparam logic [1:0] O0 = 2'b00, OH = 2'b10, ZS = 2'b01;
  localparam int NV = 33;

  localparam vec_t VT [NV] = '{
    mk(SC, CS, WG, O0, 6'h08, 1, 32'h11111111, 0, 0, 2),              // R2
    mk(SC, CS, WG, O0, 6'h09, 1, 32'h22222222, 0, 0, 2),
    mk(SC, CS, WG, O0, 6'h0A, 1, 32'h33333333, 0, 0, 2),
    mk(SC, CS, WG, O0, 6'h0B, 1, 32'h44444444, 0, 0, 2),
    mk(SP, CS, WG, O0, 6'h08, 0, 0, 1, 32'h11111111, 1),              // R1 write ctrl active
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h22222222, 6),              // R6
    mk(SH, CS, RD, O0, 6'h00, 0, 0, 1, 32'h22222222, 7),              // R7
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h33333333, 6),
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h44444444, 6),
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h11111111, 6),              // R6 wrap
    mk(SP, CS, RD, O0, 6'h0A, 0, 0, 1, 32'h33333333, 13),             // R13
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h44444444, 6),
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h11111111, 6),              // R6 mid-burst wrap
    mk(SC, CS, 6'b101010, OH, 6'h08, 1, 32'hAABBCCDD, 0, 0, 4),       // R4 lanes 0,2
    mk(SP, CS, RD, O0, 6'h08, 0, 0, 1, 32'h11BB11DD, 4),              // R4
    mk(SC, CS, 6'b101111, O0, 6'h09, 0, 0, 1, 32'h22222222, 3),       // R3 no lane
    mk(SC, CS, 6'b110000, O0, 6'h0A, 0, 0, 1, 32'h33333333, 3),       // R3 bweN high
    mk(SP, CS, RD, O0, 6'h10, 0, 0, 0, 0, 2),
    mk(SH, CS, WG, OH, 6'h00, 1, 32'h66666666, 0, 0, 2),              // R2 write held addr
    mk(SA, CS, WG, OH, 6'h00, 1, 32'h77777777, 0, 0, 2),              // R2 write advanced
    mk(SP, CS, RD, O0, 6'h10, 0, 0, 1, 32'h66666666, 2),
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, 32'h77777777, 2),
    mk(SC, CS, WG, O0, 6'h20, 0, 0, 1, REL, 9),                       // R9
    mk(SC, 3'b000, RD, O0, 6'h08, 0, 0, 1, REL, 5),                   // R5 ce2 low
    mk(SA, CS, RD, O0, 6'h00, 0, 0, 1, REL, 5),                       // R5 stays off
    mk(SP, CS, RD, O0, 6'h08, 0, 0, 1, 32'h11BB11DD, 1),
    mk(SP, 3'b011, RD, O0, 6'h08, 0, 0, 1, REL, 5),                   // R5 ce3N high
    mk(SP, CS, RD, O0, 6'h08, 0, 0, 1, 32'h11BB11DD, 1),
    mk(SP, 3'b110, RD, O0, 6'h0B, 0, 0, 1, 32'h11BB11DD, 11),         // R11 ignored
    mk(SC, 3'b110, RD, O0, 6'h0B, 0, 0, 1, REL, 11),                  // R11 deselect
    mk(SP, CS, RD, O0, 6'h09, 0, 0, 1, 32'h22222222, 1),
    mk(SC, CS, WG, ZS, 6'h0B, 0, 0, 1, REL, 10),                      // R10 sleep
    mk(SH, CS, RD, O0, 6'h00, 0, 0, 1, 32'h22222222, 10)              // R10 resume
  };

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input int r);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: dq=%h expected %h", r, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    {adspN, adscN, advN} = v.strb;
    {ce1N, ce2, ce3N}    = v.ce;
    {gwN, bweN, bwN}     = v.wr;
    {oeN, zz}            = v.oz;
    addr   = v.a;
    tbDrv  = v.drv;
    tbData = v.wd;
    @(posedge clk);
    #5;
    if (v.chk) check(dq, v.ex, int'(v.req));
  endtask

  task automatic idle();
    {adspN, adscN, advN} = SH;
    {gwN, bweN, bwN}     = RD;
    tbDrv = 1'b0;
    zz = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, got running expected done");
      finishRun();
    end
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    #5;
    check(dq, REL, 12);               // R12 bus released in reset
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    check(dq, REL, 12);               // R12 still deselected after reset

    for (int i = 0; i < NV; i++) applyVec(VT[i]);

    // R8: asynchronous output enable within one cycle
    applyVec(mk(SP, CS, RD, O0, 6'h0B, 0, 0, 1, 32'h44444444, 13));   // R13
    oeN = 1'b1;
    #2;
    check(dq, REL, 8);                // R8 released without a clock
    oeN = 1'b0;
    #2;
    check(dq, 32'h44444444, 8);       // R8 driven again without a clock

    // R12: asynchronous reset releases the bus mid-read
    @(negedge clk);
    idle();
    #2;
    rstN = 1'b0;
    #1;
    check(dq, REL, 12);
    @(posedge clk);
    #5;
    check(dq, REL, 12);

    done = 1;
    finishRun();
  end
endmodule